// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage shift register that either captures a whole parallel word at once or moves its contents one place per shift-clock edge toward a single serial output. It runs entirely on a fast system clock. The external shift clock and a clock-inhibit input are treated as slow signals. They are OR-combined into a gated shift clock, passed through a synchronizer, and a rising edge of that gated clock starts one shift.

A low level on the mode input loads the parallel bus on every system clock and does not wait for a shift edge. A high level on the mode input enables serial shifting. The serial input feeds the first stage, which holds parallel bit 0. The output is taken from the last stage, which holds parallel bit 7. The inhibit input may only be raised while the shift clock is high, so that raising it never produces a rising edge.

Top module: `piso_shift_reg`

## Requirements
- R1: While `rst_n` is low at a system clock edge, all stages clear, so that `q_out` is 0 and `q_out_n` is 1 after that edge.
- R2: While `shift_mode` is low at a system clock edge, the stages take `par_in`, with bit i going into stage i, without any shift-clock edge. `q_out` then shows `par_in[7]`.
- R3: Rising edges of the gated shift clock that arrive while `shift_mode` is low cause no shift. After the load the stages hold exactly `par_in`.
- R4: A shift happens on the third system clock edge after `sclk` rises (synchronizer depth plus one). The output stays unchanged at the first two edges.
- R5: After a load, successive shifts present parallel bits 6 down to 0 on `q_out`. After that come the `ser_in` values sampled at the first, second and later shifts.
- R6: While `sclk_inh` is high, toggling `sclk` causes no shift.
- R7: Raising `sclk_inh` while `sclk` is high causes no shift. Lowering it while `sclk` is low causes no shift either. The next `sclk` rise shifts again.
- R8: With `shift_mode` high and no gated rising edge, the stages hold their value, and a falling edge of `sclk` does not shift.
- R9: `q_out_n` is always the inverse of `q_out`.
- R10: When `shift_mode` returns high after a load, the loaded word is held until the first gated rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_mode | input | 1 | 1 = shift on gated edges, 0 = parallel load |
| ser_in | input | 1 | Serial data into stage 0 |
| sclk | input | 1 | External shift clock |
| sclk_inh | input | 1 | Shift clock inhibit, OR-combined with `sclk` |
| par_in | input | 8 | Parallel word, bit i into stage i |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Inverse of last stage |

## Verification
A wrong value in a middle stage is invisible at the ports until enough shifts carry it to the last stage. It therefore shows up as a wrong `q_out` bit up to seven shifts later. A fault in the edge-detect history shows within three system clocks of a shift-clock rise: either `q_out` moves when it should not, or it fails to move at the expected edge. A missed or extra shift then offsets every following bit in the serial stream. The bench compares against a behavioural model on every clock, so such offsets are caught at the first differing bit.

// File: rtl/piso_pkg.sv
package piso_pkg;
   typedef enum logic {
      OP_LOAD  = 1'b0,
      OP_SHIFT = 1'b1
   } piso_op_e;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_SHIFT = 2'd2,
      ACT_CLEAR = 2'd3
   } piso_act_e;

   function automatic piso_act_e piso_decide(input logic rst_n,
                                             input piso_op_e op,
                                             input logic edge_seen);
      if (!rst_n)               return ACT_CLEAR;
      else if (op == OP_LOAD)   return ACT_LOAD;
      else if (edge_seen)       return ACT_SHIFT;
      else                      return ACT_HOLD;
   endfunction
endpackage

// File: rtl/piso_gated_edge.sv
module piso_gated_edge #(
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic sclk_inh,
   output logic rise_evt
);
   localparam int LAST = SYNC_DEPTH - 1;

   if (SYNC_DEPTH < 2) begin : g_bad_depth
      $error("piso_gated_edge: SYNC_DEPTH must be at least 2");
   end

   logic                  gated_raw;
   logic [SYNC_DEPTH-1:0] sync_q;
   logic                  hist_q;

   assign gated_raw = sclk | sclk_inh;

   for (genvar k = 0; k < SYNC_DEPTH; k++) begin : g_sync
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[k] <= 1'b0;
            else        sync_q[k] <= gated_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[k] <= 1'b0;
            else        sync_q[k] <= sync_q[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= sync_q[LAST];
   end

   assign rise_evt = sync_q[LAST] & ~hist_q;
endmodule

// File: rtl/piso_stage_chain.sv
module piso_stage_chain
   import piso_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  piso_op_e          op,
   input  logic              rise_evt,
   input  logic              ser_in,
   input  logic [STAGES-1:0] par_in,
   output logic [STAGES-1:0] stage_q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("piso_stage_chain: STAGES must be at least 2");
   end

   piso_act_e act;
   assign act = piso_decide(rst_n, op, rise_evt);

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic shift_src;
      if (i == 0) begin : g_head
         assign shift_src = ser_in;
      end else begin : g_body
         assign shift_src = stage_q[i-1];
      end

      always_ff @(posedge clk) begin
         unique case (act)
            ACT_CLEAR: stage_q[i] <= 1'b0;
            ACT_LOAD:  stage_q[i] <= par_in[i];
            ACT_SHIFT: stage_q[i] <= shift_src;
            default:   stage_q[i] <= stage_q[i];
         endcase
      end
   end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
   import piso_pkg::*;
#(
   parameter int STAGES     = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_mode,
   input  logic              ser_in,
   input  logic              sclk,
   input  logic              sclk_inh,
   input  logic [STAGES-1:0] par_in,
   output logic              q_out,
   output logic              q_out_n
);
   localparam int TAIL = STAGES - 1;

   logic              shift_evt;
   logic [STAGES-1:0] stage_q;
   piso_op_e          op;

   assign op = shift_mode ? OP_SHIFT : OP_LOAD;

   piso_gated_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .sclk_inh (sclk_inh),
      .rise_evt (shift_evt)
   );

   piso_stage_chain #(.STAGES(STAGES)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .rise_evt (shift_evt),
      .ser_in   (ser_in),
      .par_in   (par_in),
      .stage_q  (stage_q)
   );

   assign q_out   = stage_q[TAIL];
   assign q_out_n = ~stage_q[TAIL];
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
   parameter int STAGES     = 8,
   parameter int SYNC_DEPTH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shift_mode,
   input logic              ser_in,
   input logic              sclk_inh,
   input logic [STAGES-1:0] par_in,
   input logic [STAGES-1:0] stage_q,
   input logic              shift_evt,
   input logic              q_out,
   input logic              q_out_n
);
   localparam int RUN_LIM = SYNC_DEPTH + 2;
   int inh_run;

   always_ff @(posedge clk) begin
      if (!rst_n)                 inh_run <= 0;
      else if (!sclk_inh)         inh_run <= 0;
      else if (inh_run < RUN_LIM) inh_run <= inh_run + 1;
   end

   assert_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (q_out == 1'b0 && stage_q == '0));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_mode |=> (stage_q == $past(par_in)));

   assert_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && shift_evt) |=>
         (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)}));

   assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_inh && inh_run >= SYNC_DEPTH + 1) |-> !shift_evt);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && !shift_evt) |=> $stable(stage_q));

   assert_comp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_out_n == ~q_out);
endmodule

bind piso_shift_reg piso_checker #(.STAGES(STAGES), .SYNC_DEPTH(SYNC_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .shift_mode (shift_mode),
   .ser_in     (ser_in),
   .sclk_inh   (sclk_inh),
   .par_in     (par_in),
   .stage_q    (stage_q),
   .shift_evt  (shift_evt),
   .q_out      (q_out),
   .q_out_n    (q_out_n)
);

// File: tb/sim_piso_shift_reg.sv
`timescale 1ns/1ps
module sim_piso_shift_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       shift_mode = 1'b1;
   logic       ser_in = 1'b0;
   logic       sclk = 1'b0;
   logic       sclk_inh = 1'b0;
   logic [7:0] par_in = 8'h00;
   logic       q_out, q_out_n;

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   piso_shift_reg u0 (
      .clk(clk), .rst_n(rst_n), .shift_mode(shift_mode), .ser_in(ser_in),
      .sclk(sclk), .sclk_inh(sclk_inh), .par_in(par_in),
      .q_out(q_out), .q_out_n(q_out_n)
   );

   // behavioural reference: word plus a queue of sampled gated-clock levels
   logic [7:0] m_word = 8'h00;
   bit         gq[$] = '{0, 0, 0};

   always @(posedge clk) begin
      bit ev;
      if (!rst_n) begin
         m_word = 8'h00;
         gq = '{0, 0, 0};
      end else begin
         ev = gq[1] && !gq[2];
         if (!shift_mode)  m_word = par_in;
         else if (ev)      m_word = {m_word[6:0], ser_in};
         gq.push_front(sclk | sclk_inh);
         void'(gq.pop_back());
      end
      #2;
      n_run++;
      if (q_out !== m_word[7]) begin
         n_fail++;
         $display("FAIL %s model: q_out=%b expected=%b", cur_req, q_out, m_word[7]);
      end
      n_run++;
      if (q_out_n !== ~q_out) begin
         n_fail++;
         $display("FAIL R9 complement: q_out_n=%b expected=%b", q_out_n, ~q_out);
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic din);
      @(negedge clk); ser_in = din; sclk = 1'b1;
      cyc(4);
      sclk = 1'b0;
      cyc(4);
   endtask

   task automatic load(input logic [7:0] w);
      @(negedge clk); par_in = w; shift_mode = 1'b0;
      @(negedge clk); shift_mode = 1'b1;
   endtask

   initial begin
      logic [7:0] w;
      logic [7:0] s;
      cyc(3);
      cur_req = "R1";
      check("R1 q_out after reset", q_out, 1'b0);
      check("R1 q_out_n after reset", q_out_n, 1'b1);
      rst_n = 1'b1;
      cyc(2);

      // R2 load and R10 hold afterwards
      cur_req = "R2";
      w = 8'hB4;
      load(w);
      check("R2 q_out shows bit 7 after load", q_out, w[7]);
      cur_req = "R10";
      par_in = 8'h00;
      cyc(10);
      check("R10 loaded word held without edge", q_out, w[7]);

      // R5 order: bits 6..0 then serial data
      cur_req = "R5";
      s = 8'b1100_1010;
      for (int k = 0; k < 7; k++) begin
         pulse(s[k]);
         check("R5 parallel bit order", q_out, w[6-k]);
      end
      pulse(s[7]);
      check("R5 first serial bit reaches output", q_out, s[0]);
      for (int k = 1; k < 4; k++) begin
         pulse(1'b0);
         check("R5 serial bit order", q_out, s[k]);
      end

      // R4 latency: load 0x80, shift once with bit 6 = 0
      cur_req = "R4";
      load(8'h80);
      @(negedge clk); sclk = 1'b1; ser_in = 1'b0;
      cyc(2);
      check("R4 unchanged after two system edges", q_out, 1'b1);
      cyc(1);
      check("R4 shifted on third system edge", q_out, 1'b0);
      sclk = 1'b0;
      cyc(4);

      // R6 / R7 inhibit
      cur_req = "R7";
      load(8'hC0);
      @(negedge clk); sclk = 1'b1;
      cyc(4);
      check("R7 shift from sclk rise", q_out, 1'b1);
      sclk_inh = 1'b1;
      cyc(5);
      check("R7 inhibit rise while sclk high no shift", q_out, 1'b1);
      cur_req = "R6";
      for (int k = 0; k < 4; k++) begin
         sclk = ~sclk;
         cyc(4);
      end
      check("R6 toggling sclk under inhibit no shift", q_out, 1'b1);
      cur_req = "R7";
      sclk = 1'b0;
      cyc(4);
      sclk_inh = 1'b0;
      cyc(5);
      check("R7 inhibit fall while sclk low no shift", q_out, 1'b1);
      pulse(1'b0);
      check("R7 shifting resumes after inhibit", q_out, 1'b0);

      // R8 falling edge only
      cur_req = "R8";
      load(8'h40);
      check("R8 load for falling-edge test", q_out, 1'b0);
      cyc(6);
      check("R8 hold with no edge", q_out, 1'b0);

      // R3 edges during load ignored
      cur_req = "R3";
      @(negedge clk); par_in = 8'h9F; shift_mode = 1'b0;
      sclk = 1'b1;
      cyc(4);
      sclk = 1'b0;
      cyc(4);
      shift_mode = 1'b1;
      cyc(6);
      check("R3 edge during load ignored", q_out, 1'b1);
      pulse(1'b0);
      check("R3 first shift after load gives bit 6", q_out, 1'b0);
      @(negedge clk); sclk = 1'b1;
      cyc(6);
      cur_req = "R8";
      sclk = 1'b0;
      cyc(6);
      check("R8 falling sclk edge no shift", q_out, 1'b0);

      // R1 reset mid-stream
      cur_req = "R1";
      load(8'hFF);
      @(negedge clk); rst_n = 1'b0;
      cyc(2);
      check("R1 reset clears loaded word", q_out, 1'b0);
      check("R1 complement after reset", q_out_n, 1'b1);
      rst_n = 1'b1;
      cyc(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule